// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Monitor

This block holds two phase-frequency detectors of a frequency synthesizer: a main loop and an auxiliary loop. Each compares a tap of the reference divider with the output of its own feedback divider. A falling edge of the reference tap raises the loop's up request, which asks for a higher VCO frequency. A falling edge of the divider output raises the down request, which asks for a lower one. Once both requests are raised, the next rising edge of the reference input clock clears them. This delayed reset keeps both requests on for one reference cycle near zero phase error, so the detector has no dead zone.

Each loop runs a small state machine with the states `PFD_IDLE`, `PFD_UP` (only up set), `PFD_DN` (only down set) and `PFD_BOTH` (both set, clear pending). The transitions are:
- `PFD_IDLE` to `PFD_UP` on a reference edge, to `PFD_DN` on a divider edge, and to `PFD_BOTH` on both at once.
- `PFD_UP` to `PFD_BOTH` on a divider edge, and `PFD_DN` to `PFD_BOTH` on a reference edge.
- `PFD_BOTH` to `PFD_IDLE`, or to `PFD_UP`, `PFD_DN` or `PFD_BOTH` when new edges arrive in the clearing cycle.
- Any state to `PFD_IDLE` when the loop is disabled.

While only one request is set, a counter measures the phase error in reference clocks. The counter is judged in `PFD_BOTH` to decide the loop's lock. The lock pin reports both loops' lock together, or, by a two-bit test select, one of the divider waveforms.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst_n` is low, all four up/down outputs and `lock_out` are 0.
- R2: A falling edge of a reference tap (sampled 1 then 0) sets that loop's up output from the next clock. A falling edge of a divider output sets the down output. A set output stays high until the pair is cleared.
- R3: When both outputs of a loop are high, they are both low after the next clock edge, unless new falling edges arrive in that same cycle; those are taken as fresh sets. Coincident edges give exactly one cycle with both high.
- R4: When a pair is cleared, the loop's lock condition becomes true if the number of cycles with only one output set was below `LOCK_TOL` (default 1, so only coincident edges lock), and false otherwise.
- R5: A loop whose enable is 0 ignores its edges, keeps up and down at 0, and counts as locked.
- R6: With test select 00, `lock_out` is the AND of both loops' lock conditions, registered once: it follows two clock edges after the clearing edge.
- R7: When only one output stays set for `2^ERR_W-1` counted cycles, the counter saturates and the loop's lock condition drops while the output stays set.
- R8: Test select 01 drives `lock_out` with `ref_main_tap` (idles low), 10 with `aux_div_n` and 11 with `main_div_n` (both idle high), each delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_en | input | 1 | Main loop enable |
| aux_en | input | 1 | Auxiliary loop enable |
| test_sel | input | 2 | Lock pin source select |
| ref_main_tap | input | 1 | Reference divider tap for the main loop, idles low |
| ref_aux_tap | input | 1 | Reference divider tap for the auxiliary loop, idles low |
| main_div_n | input | 1 | Main divider output, idles high |
| aux_div_n | input | 1 | Auxiliary divider output, idles high |
| main_up | output | 1 | Main loop raise-frequency request |
| main_dn | output | 1 | Main loop lower-frequency request |
| aux_up | output | 1 | Auxiliary raise-frequency request |
| aux_dn | output | 1 | Auxiliary lower-frequency request |
| lock_out | output | 1 | Lock indication or selected test waveform |

## Verification
Setting and clearing can fall in the same cycle: a reference edge can arrive on the very clock that clears a set pair. The bench provokes this with a vector whose second reference edge lands on the clearing edge of the first pair. It judges the result by counting the cycles with up high (continuous across the clear) and with down high (two separate single cycles), and by the lock result of the second comparison. Coincident edges on both inputs, which set and start the clear together, are judged the same way.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'b00,
        PFD_UP   = 2'b01,
        PFD_DN   = 2'b10,
        PFD_BOTH = 2'b11
    } pfd_state_e;

    typedef enum logic [1:0] {
        TSEL_LOCK = 2'b00,
        TSEL_REF  = 2'b01,
        TSEL_AUX  = 2'b10,
        TSEL_MAIN = 2'b11
    } tsel_e;

    localparam int NUM_LOOPS = 2;
    localparam int LOOP_MAIN = 0;
    localparam int LOOP_AUX  = 1;

endpackage

// File: rtl/pfd_fall_det.sv
module pfd_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);
    logic prev_q;

    // prev_q is cleared in reset so that a low input at release is not an edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    assign fall = prev_q & ~sig;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_lock_pkg::*;
#(
    parameter int ERR_W    = 4,
    parameter int LOCK_TOL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ref_fall,
    input  logic div_fall,
    output logic up,
    output logic dn,
    output logic lock_ok
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    pfd_state_e state_q, state_d;
    logic [ERR_W-1:0] err_cnt_q;
    logic             lock_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFD_IDLE, PFD_BOTH: begin
                if (ref_fall && div_fall) state_d = PFD_BOTH;
                else if (ref_fall)        state_d = PFD_UP;
                else if (div_fall)        state_d = PFD_DN;
                else                      state_d = PFD_IDLE;
            end
            PFD_UP: if (div_fall) state_d = PFD_BOTH;
            PFD_DN: if (ref_fall) state_d = PFD_BOTH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)   state_q <= PFD_IDLE;
        else if (!en) state_q <= PFD_IDLE;
        else          state_q <= state_d;
    end

    // outputs
    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state_q)
            PFD_IDLE: ;
            PFD_UP:   up = 1'b1;
            PFD_DN:   dn = 1'b1;
            PFD_BOTH: begin
                up = 1'b1;
                dn = 1'b1;
            end
        endcase
    end

    // phase error counter and lock judgement
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            err_cnt_q <= '0;
            lock_q    <= 1'b0;
        end else begin
            unique case (state_q)
                PFD_UP, PFD_DN: begin
                    if (err_cnt_q == CNT_MAX) lock_q <= 1'b0;
                    else                      err_cnt_q <= err_cnt_q + 1'b1;
                end
                PFD_BOTH: begin
                    lock_q    <= (int'(err_cnt_q) < LOCK_TOL);
                    err_cnt_q <= '0;
                end
                PFD_IDLE: ;
            endcase
        end
    end

    assign lock_ok = lock_q;

    // R2
    up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up && !dn && !div_fall) |=> up);
    // R3
    pair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up && dn && !ref_fall && !div_fall) |=> (!up && !dn));
    // R5
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!up && !dn && !lock_ok));
    // R4
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_ok) |-> $past(up && dn));
    // R7
    sat_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (up ^ dn) && err_cnt_q == CNT_MAX) |=> !lock_ok);
endmodule

// File: rtl/pfd_lock_sel.sv
module pfd_lock_sel
    import pfd_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] test_sel,
    input  logic       main_ok,
    input  logic       aux_ok,
    input  logic       main_en,
    input  logic       aux_en,
    input  logic       ref_tap,
    input  logic       aux_div_n,
    input  logic       main_div_n,
    output logic       lock_out
);
    tsel_e sel;
    logic  pick;
    logic  out_q;

    assign sel = tsel_e'(test_sel);

    always_comb begin
        unique case (sel)
            TSEL_LOCK: pick = (main_ok | ~main_en) & (aux_ok | ~aux_en);
            TSEL_REF:  pick = ref_tap;
            TSEL_AUX:  pick = aux_div_n;
            TSEL_MAIN: pick = main_div_n;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= pick;
    end

    assign lock_out = out_q;

    // R8
    ref_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 2'b01) |=> (lock_out == $past(ref_tap)));
    // R8
    main_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 2'b11) |=> (lock_out == $past(main_div_n)));
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_lock_pkg::*;
#(
    parameter int ERR_W    = 4,
    parameter int LOCK_TOL = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_en,
    input  logic       aux_en,
    input  logic [1:0] test_sel,
    input  logic       ref_main_tap,
    input  logic       ref_aux_tap,
    input  logic       main_div_n,
    input  logic       aux_div_n,
    output logic       main_up,
    output logic       main_dn,
    output logic       aux_up,
    output logic       aux_dn,
    output logic       lock_out
);
    logic [NUM_LOOPS-1:0] en_v, tap_v, div_v;
    logic [NUM_LOOPS-1:0] rfall_v, dfall_v, up_v, dn_v, ok_v;

    assign en_v[LOOP_MAIN]  = main_en;
    assign en_v[LOOP_AUX]   = aux_en;
    assign tap_v[LOOP_MAIN] = ref_main_tap;
    assign tap_v[LOOP_AUX]  = ref_aux_tap;
    assign div_v[LOOP_MAIN] = main_div_n;
    assign div_v[LOOP_AUX]  = aux_div_n;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        pfd_fall_det u_ref_fall (
            .clk(clk), .rst_n(rst_n), .sig(tap_v[g]), .fall(rfall_v[g])
        );
        pfd_fall_det u_div_fall (
            .clk(clk), .rst_n(rst_n), .sig(div_v[g]), .fall(dfall_v[g])
        );
        pfd_core #(.ERR_W(ERR_W), .LOCK_TOL(LOCK_TOL)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_v[g]),
            .ref_fall (rfall_v[g]),
            .div_fall (dfall_v[g]),
            .up       (up_v[g]),
            .dn       (dn_v[g]),
            .lock_ok  (ok_v[g])
        );
    end

    assign main_up = up_v[LOOP_MAIN];
    assign main_dn = dn_v[LOOP_MAIN];
    assign aux_up  = up_v[LOOP_AUX];
    assign aux_dn  = dn_v[LOOP_AUX];

    pfd_lock_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_sel   (test_sel),
        .main_ok    (ok_v[LOOP_MAIN]),
        .aux_ok     (ok_v[LOOP_AUX]),
        .main_en    (main_en),
        .aux_en     (aux_en),
        .ref_tap    (ref_main_tap),
        .aux_div_n  (aux_div_n),
        .main_div_n (main_div_n),
        .lock_out   (lock_out)
    );

    // R6
    lock_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 2'b00 && main_en && !ok_v[LOOP_MAIN]) |=> !lock_out);
    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!main_up && !main_dn && !aux_up && !aux_dn);
        end
    end
endmodule

// File: tb/pfd_lock_top_bench.sv
module pfd_lock_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 16;
    localparam int NV  = 7;

    // vector table: falling-edge masks (bit t = edge at clock t of window),
    // expected up cycles, down cycles and lock after the window
    localparam logic [15:0] V_REF [NV] = '{16'h0008, 16'h0008, 16'h0040, 16'h0004,
                                           16'h0010, 16'h0024, 16'h0200};
    localparam logic [15:0] V_DIV [NV] = '{16'h0008, 16'h0020, 16'h0010, 16'h0004,
                                           16'h0020, 16'h0090, 16'h0200};
    localparam int   V_UP  [NV] = '{1, 3, 1, 1, 2, 6, 1};
    localparam int   V_DN  [NV] = '{1, 1, 3, 1, 1, 2, 1};
    localparam logic V_LK  [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_en = 1'b0, aux_en = 1'b0;
    logic [1:0] test_sel = 2'b00;
    logic       ref_main_tap = 1'b0, ref_aux_tap = 1'b0;
    logic       main_div_n = 1'b1, aux_div_n = 1'b1;
    logic       main_up, main_dn, aux_up, aux_dn, lock_out;

    int checks = 0;
    int errors = 0;

    pfd_lock_top u_pfd_lock_top (
        .clk(clk), .rst_n(rst_n), .main_en(main_en), .aux_en(aux_en),
        .test_sel(test_sel), .ref_main_tap(ref_main_tap), .ref_aux_tap(ref_aux_tap),
        .main_div_n(main_div_n), .aux_div_n(aux_div_n),
        .main_up(main_up), .main_dn(main_dn), .aux_up(aux_up), .aux_dn(aux_dn),
        .lock_out(lock_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one comparison window on the chosen loop (0 main, 1 aux)
    task automatic run_win(input int which, input logic [15:0] rm, input logic [15:0] dm,
                           input int eu, input int ed, input logic el, input string req);
        int nu = 0;
        int nd = 0;
        for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            nu += (which == 0) ? int'(main_up) : int'(aux_up);
            nd += (which == 0) ? int'(main_dn) : int'(aux_dn);
            if (which == 0) begin
                ref_main_tap = (c + 1 < WIN) ? rm[c + 1] : 1'b0;
                main_div_n   = ~dm[c];
            end else begin
                ref_aux_tap  = (c + 1 < WIN) ? rm[c + 1] : 1'b0;
                aux_div_n    = ~dm[c];
            end
        end
        @(negedge clk);
        nu += (which == 0) ? int'(main_up) : int'(aux_up);
        nd += (which == 0) ? int'(main_dn) : int'(aux_dn);
        check(nu == eu, req, "up cycles", nu, eu);
        check(nd == ed, req, "down cycles", nd, ed);
        check(lock_out == el, req, "lock", int'(lock_out), int'(el));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(lock_out == 1'b0, "R1", "lock in reset", int'(lock_out), 0);
        check(!main_up && !main_dn, "R1", "main pair in reset", int'({main_up, main_dn}), 0);
        check(!aux_up && !aux_dn, "R1", "aux pair in reset", int'({aux_up, aux_dn}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R5: both loops disabled count as locked
        check(lock_out == 1'b1, "R5", "lock with loops off", int'(lock_out), 1);
        // R5: edges ignored while disabled
        run_win(0, 16'h0004, 16'h0020, 0, 0, 1'b1, "R5");

        // vector table on the main loop (R2, R3, R4, R6)
        main_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            run_win(0, V_REF[v], V_DIV[v], V_UP[v], V_DN[v], V_LK[v], "R2_R3_R4");
        end

        // R6: AND with the auxiliary loop
        aux_en = 1'b1;
        repeat (2) @(negedge clk);
        check(lock_out == 1'b0, "R6", "aux enabled not yet judged", int'(lock_out), 0);
        run_win(1, 16'h0008, 16'h0008, 1, 1, 1'b1, "R6");
        run_win(1, 16'h0004, 16'h0040, 5, 1, 1'b0, "R6");
        aux_en = 1'b0;
        repeat (2) @(negedge clk);
        check(lock_out == 1'b1, "R6", "aux off again", int'(lock_out), 1);

        // R7: missing divider edge
        ref_main_tap = 1'b1;
        @(negedge clk);
        ref_main_tap = 1'b0;
        repeat (25) @(negedge clk);
        check(main_up == 1'b1 && main_dn == 1'b0, "R7", "up held", int'({main_up, main_dn}), 2);
        check(lock_out == 1'b0, "R7", "lock after saturation", int'(lock_out), 0);
        main_div_n = 1'b0;
        @(negedge clk);
        main_div_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!main_up && !main_dn, "R7", "pair cleared", int'({main_up, main_dn}), 0);
        check(lock_out == 1'b0, "R7", "lock after late edge", int'(lock_out), 0);
        run_win(0, 16'h0010, 16'h0010, 1, 1, 1'b1, "R4");

        // R8: test select
        main_en = 1'b0;
        test_sel = 2'b01;
        ref_main_tap = 1'b1;
        @(negedge clk);
        check(lock_out == 1'b1, "R8", "ref tap high", int'(lock_out), 1);
        ref_main_tap = 1'b0;
        @(negedge clk);
        check(lock_out == 1'b0, "R8", "ref tap low", int'(lock_out), 0);
        test_sel = 2'b10;
        aux_div_n = 1'b0;
        @(negedge clk);
        check(lock_out == 1'b0, "R8", "aux div low", int'(lock_out), 0);
        aux_div_n = 1'b1;
        @(negedge clk);
        check(lock_out == 1'b1, "R8", "aux div high", int'(lock_out), 1);
        test_sel = 2'b11;
        main_div_n = 1'b0;
        @(negedge clk);
        check(lock_out == 1'b0, "R8", "main div low", int'(lock_out), 0);
        main_div_n = 1'b1;
        @(negedge clk);
        check(lock_out == 1'b1, "R8", "main div high", int'(lock_out), 1);
        test_sel = 2'b00;
        main_div_n = 1'b0;
        @(negedge clk);
        check(lock_out == 1'b1, "R8", "select 00 gives lock", int'(lock_out), 1);
        main_div_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule